// File: doc/BRIEF.md
# Viewport Scale-and-Offset Transformer

This block converts vertex coordinates from a user coordinate space into screen coordinates. For each image the host first supplies the user-space bounding box, as a lower and an upper corner, together with the screen width and height. From these the block derives one scale factor per axis, equal to the screen extent divided by the user-space span. Two restoring dividers produce the two factors side by side, one quotient bit per clock cycle. Once both factors are known, the block accepts a stream of (x, y) vertices and returns, for each one, the offset from the lower corner multiplied by the axis factor.

All values are signed two's-complement fixed point with `FRAC` fraction bits. With the defaults this is Q16.16 in 32 bits, and the screen extents are read as unsigned. The vertex path is two register stages deep: an offset stage, then a multiply stage. It uses valid/ready flow control on both sides. When both lower-corner coordinates are zero, the controller runs in a multiply-only state in which the offset subtraction is bypassed.

A new bounding box may be presented at any time. The block stops accepting vertices at once. Vertices already inside the block finish with the old factors, and only then does the new box become active and the dividers start.

Top module: `vp_xform`

## Requirements
- R1: While reset is asserted and just after it is released, `ratio_ready`, `in_ready` and `out_valid` are 0.
- R2: After a box is committed, each axis factor equals floor(ext × 2^FRAC / (hi − lo)), computed on the raw fixed-point values and clipped to 2^(DW−1)−1. `ratio_ready` rises within DW+FRAC+4 cycles of the commit, and `in_ready` stays 0 until then.
- R3: With a nonzero lower corner, each output equals floor((c − lo) × factor / 2^FRAC) for its axis, computed on raw values.
- R4: When both lower-corner coordinates are zero, the multiply-only state gives floor(c × factor / 2^FRAC) on each axis.
- R5: When hi ≤ lo on an axis, `cfg_err` is set for that axis (bit 0 for x, bit 1 for y), that factor is 0 and every output on that axis is 0. The error bits are recomputed at each commit.
- R6: Every accepted vertex gives exactly one output, and outputs leave in acceptance order.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_x` and `out_y` do not change.
- R8: After a `cfg_load` pulse, `in_ready` is 0 from the next cycle. Vertices accepted before the pulse complete with the old box, and `ratio_ready` stays 0 while any of them remains inside the block.
- R9: An output whose exact value lies outside the signed DW-bit range is clipped to the largest or smallest representable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle pulse that captures a new box and screen size |
| cfg_min_x | input | DW | User-space lower x, signed fixed point |
| cfg_min_y | input | DW | User-space lower y, signed fixed point |
| cfg_max_x | input | DW | User-space upper x, signed fixed point |
| cfg_max_y | input | DW | User-space upper y, signed fixed point |
| cfg_scr_w | input | DW | Screen width, unsigned fixed point |
| cfg_scr_h | input | DW | Screen height, unsigned fixed point |
| ratio_ready | output | 1 | Both axis factors are valid and the vertex path is open |
| cfg_err | output | 2 | Per-axis empty-span flag (bit 0 x, bit 1 y) |
| in_valid | input | 1 | Input vertex valid |
| in_ready | output | 1 | Input vertex accepted this cycle if valid |
| in_x | input | DW | Input x, signed fixed point |
| in_y | input | DW | Input y, signed fixed point |
| out_valid | output | 1 | Output vertex valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_x | output | DW | Screen x, signed fixed point |
| out_y | output | DW | Screen y, signed fixed point |

## Verification
The embedded properties assume that `cfg_load` lasts one cycle and that the configuration buses are meaningful only in that cycle. The bench drives them in exactly that way. They also assume that the downstream side may withhold `out_ready` for any length of time, so the bench mixes periods of full flow, a one-in-three stall pattern and a complete stall.

The reference model uses 64-bit arithmetic. The stimulus therefore keeps coordinates within ±256.0, and each factor stays at or below the clip value, so that every product is exact in that model. The box sequence covers each corner the properties reason about:
- a general offset box;
- a zero-corner box;
- an empty x span;
- a one-LSB span with a reversed y range;
- a reload while the pipeline is full.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY,    // no factors yet
    ST_DRAIN,    // new box pending, waiting for the pipeline to empty
    ST_DIVIDE,   // dividers working
    ST_RUN_SUB,  // streaming with offset subtraction
    ST_RUN_MUL   // streaming, both lower corners zero: multiply only
  } vpx_state_e;
endpackage

// File: rtl/vpx_div.sv
module vpx_div #(
  parameter int NW  = 48,  // dividend bits = quotient bits produced
  parameter int DDW = 33,  // divisor bits
  parameter int QW  = 32   // clipped quotient width
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           zero_div,
  input  logic [NW-1:0]  dividend,
  input  logic [DDW-1:0] divisor,
  output logic           busy,
  output logic [QW-1:0]  quot
);
  localparam int CW = $clog2(NW + 1);

  logic           busy_q, busy_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [DDW:0]   rem_q, rem_d;
  logic [NW-1:0]  acc_q, acc_d;
  logic [DDW-1:0] div_q, div_d;
  logic [DDW:0]   rem_sh;
  logic [DDW+1:0] diff;
  logic           qbit;
  logic           en;

  always_comb begin
    rem_sh = {rem_q[DDW-1:0], acc_q[NW-1]};
    diff   = {1'b0, rem_sh} - {2'b00, div_q};
    qbit   = ~diff[DDW+1];
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    acc_d  = acc_q;
    div_d  = div_q;
    en     = 1'b0;
    if (start) begin
      en     = 1'b1;
      busy_d = ~zero_div;
      cnt_d  = '0;
      rem_d  = '0;
      acc_d  = zero_div ? '0 : dividend;
      div_d  = divisor;
    end else if (busy_q) begin
      en     = 1'b1;
      rem_d  = qbit ? diff[DDW:0] : rem_sh;
      acc_d  = {acc_q[NW-2:0], qbit};
      cnt_d  = cnt_q + 1'b1;
      busy_d = (cnt_q != CW'(NW - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      div_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      acc_q  <= acc_d;
      div_q  <= div_d;
    end
  end

  assign busy = busy_q;
  assign quot = (|acc_q[NW-1:QW-1]) ? {1'b0, {(QW-1){1'b1}}} : acc_q[QW-1:0];

  // R2: the partial remainder stays below the divisor at every step
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < {1'b0, div_q}));
endmodule

// File: rtl/vpx_lane.sv
module vpx_lane #(
  parameter int DW   = 32,
  parameter int FRAC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld1,
  input  logic          ld2,
  input  logic          skip_sub,
  input  logic [DW-1:0] coord,
  input  logic [DW-1:0] min_val,
  input  logic [DW-1:0] ratio,
  output logic [DW-1:0] result
);
  localparam int SW = DW + 1;
  localparam int PW = 2 * SW;

  logic [SW-1:0]        d1_q, d1_d;
  logic [PW-1:0]        prod;
  logic signed [PW-1:0] shifted;
  logic [DW-1:0]        res_q, res_d;
  logic                 in_range;

  always_comb begin
    if (skip_sub) d1_d = {coord[DW-1], coord};
    else          d1_d = {coord[DW-1], coord} - {min_val[DW-1], min_val};
  end

  always_comb begin
    prod     = {{SW{d1_q[SW-1]}}, d1_q} * {{(SW+1){1'b0}}, ratio};
    shifted  = $signed(prod) >>> FRAC;
    in_range = (&shifted[PW-1:DW-1]) || !(|shifted[PW-1:DW-1]);
    if (in_range)        res_d = shifted[DW-1:0];
    else if (prod[PW-1]) res_d = {1'b1, {(DW-1){1'b0}}};
    else                 res_d = {1'b0, {(DW-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   d1_q <= '0;
    else if (ld1) d1_q <= d1_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   res_q <= '0;
    else if (ld2) res_q <= res_d;
  end

  assign result = res_q;

  // R5: a zero factor can only produce a zero coordinate
  p_zero_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld2 && (ratio == '0)) |=> (result == '0));
endmodule

// File: rtl/vpx_ctrl.sv
module vpx_ctrl
  import vpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_load,
  input  logic       pipe_empty,
  input  logic [1:0] div_busy,
  input  logic       mins_zero,
  output vpx_state_e state,
  output logic       commit
);
  vpx_state_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    commit = 1'b0;
    unique case (st_q)
      ST_EMPTY: if (cfg_load) st_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!cfg_load && pipe_empty) begin
          commit = 1'b1;
          st_d   = ST_DIVIDE;
        end
      end
      ST_DIVIDE: begin
        if (cfg_load)            st_d = ST_DRAIN;
        else if (div_busy == '0) st_d = mins_zero ? ST_RUN_MUL : ST_RUN_SUB;
      end
      ST_RUN_SUB, ST_RUN_MUL: if (cfg_load) st_d = ST_DRAIN;
      default: st_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_EMPTY;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/vp_xform.sv
module vp_xform
  import vpx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int FRAC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [DW-1:0] cfg_min_x,
  input  logic [DW-1:0] cfg_min_y,
  input  logic [DW-1:0] cfg_max_x,
  input  logic [DW-1:0] cfg_max_y,
  input  logic [DW-1:0] cfg_scr_w,
  input  logic [DW-1:0] cfg_scr_h,
  output logic          ratio_ready,
  output logic [1:0]    cfg_err,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_x,
  input  logic [DW-1:0] in_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_x,
  output logic [DW-1:0] out_y
);
  localparam int NAX = 2;
  localparam int NW  = DW + FRAC;
  localparam int DDW = DW + 1;

  vpx_state_e            state;
  logic                  commit;
  logic [NAX-1:0]        div_busy;
  logic [NAX-1:0]        min_zero;
  logic [NAX-1:0][DW-1:0] c_min, c_max, c_scr, c_in, c_res;
  logic                  v1_q, v1_d, v2_q, v2_d;
  logic                  adv2, ld1, ld2, run;

  assign c_min = {cfg_min_y, cfg_min_x};
  assign c_max = {cfg_max_y, cfg_max_x};
  assign c_scr = {cfg_scr_h, cfg_scr_w};
  assign c_in  = {in_y, in_x};

  vpx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .pipe_empty(!v1_q && !v2_q),
    .div_busy  (div_busy),
    .mins_zero (&min_zero),
    .state     (state),
    .commit    (commit)
  );

  // handshake and stage occupancy
  always_comb begin
    run      = (state == ST_RUN_SUB) || (state == ST_RUN_MUL);
    adv2     = !v2_q || out_ready;
    in_ready = run && (!v1_q || adv2);
    ld1      = in_valid && in_ready;
    ld2      = v1_q && adv2;
    v1_d     = ld1 || (v1_q && !ld2);
    v2_d     = adv2 ? v1_q : v2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic [DW-1:0] sh_min_q, sh_max_q, sh_scr_q, act_min_q, ratio;
    logic [DW:0]   span;
    logic          span_bad, err_q;

    always_comb begin
      span     = {sh_max_q[DW-1], sh_max_q} - {sh_min_q[DW-1], sh_min_q};
      span_bad = span[DW] || (span == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_min_q <= '0;
        sh_max_q <= '0;
        sh_scr_q <= '0;
      end else if (cfg_load) begin
        sh_min_q <= c_min[a];
        sh_max_q <= c_max[a];
        sh_scr_q <= c_scr[a];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_min_q <= '0;
        err_q     <= 1'b0;
      end else if (commit) begin
        act_min_q <= sh_min_q;
        err_q     <= span_bad;
      end
    end

    vpx_div #(.NW(NW), .DDW(DDW), .QW(DW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (commit),
      .zero_div(span_bad),
      .dividend({sh_scr_q, {FRAC{1'b0}}}),
      .divisor (span),
      .busy    (div_busy[a]),
      .quot    (ratio)
    );

    vpx_lane #(.DW(DW), .FRAC(FRAC)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld1     (ld1),
      .ld2     (ld2),
      .skip_sub(state == ST_RUN_MUL),
      .coord   (c_in[a]),
      .min_val (act_min_q),
      .ratio   (ratio),
      .result  (c_res[a])
    );

    assign min_zero[a] = (act_min_q == '0);
    assign cfg_err[a]  = err_q;
  end

  assign ratio_ready = run;
  assign out_valid   = v2_q;
  assign out_x       = c_res[0];
  assign out_y       = c_res[1];

  // R8: a load closes the input side on the next cycle
  p_load_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !in_ready);

  // R8: the dividers only run with the vertex path empty
  p_divide_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIVIDE) |-> (!v1_q && !out_valid));

  // R7: a stalled output is held
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)));

  // R2: no vertex is taken while factors are not ready
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ratio_ready) |-> !in_ready);
endmodule

// File: tb/sim_vp_xform.sv
module sim_vp_xform;
  localparam int DW   = 32;
  localparam int FRAC = 16;
  localparam longint QMAX = 64'sd2147483647;
  localparam longint QMIN = -64'sd2147483648;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [DW-1:0] cfg_min_x, cfg_min_y, cfg_max_x, cfg_max_y, cfg_scr_w, cfg_scr_h;
  logic          ratio_ready;
  logic [1:0]    cfg_err;
  logic          in_valid, in_ready;
  logic [DW-1:0] in_x, in_y;
  logic          out_valid, out_ready;
  logic [DW-1:0] out_x, out_y;

  always #5 clk = ~clk;

  vp_xform #(.DW(DW), .FRAC(FRAC)) u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int rd_mode = 0;
  int cyc = 0;
  bit done = 0;

  longint cmin [2];
  longint crat [2];
  bit     cerr [2];

  int eq_x[$];
  int eq_y[$];
  int eq_t[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint fx(input real r);
    return longint'($rtoi(r * 65536.0));
  endfunction

  function automatic longint exp_ratio(input longint scr, input longint span);
    longint q;
    if (span <= 0) return 0;
    q = (scr <<< FRAC) / span;
    if (q > QMAX) q = QMAX;
    return q;
  endfunction

  function automatic int exp_out(input longint c, input longint mn, input longint r);
    longint p;
    p = ((c - mn) * r) >>> FRAC;
    if (p > QMAX) p = QMAX;
    if (p < QMIN) p = QMIN;
    return int'(p);
  endfunction

  // receiver: backpressure patterns, order, values and hold checks
  initial begin : rx
    bit hold_p = 0;
    logic [DW-1:0] hx, hy;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      case (rd_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = 1'b0;
      endcase
      #2;
      if (hold_p) begin // R7
        check(out_valid && out_x == hx && out_y == hy, "R7 held x", longint'(out_x), longint'(hx));
      end
      hold_p = out_valid && !out_ready;
      hx = out_x;
      hy = out_y;
      if (out_valid && out_ready) begin
        if (eq_x.size() == 0) begin
          check(1'b0, "R6 unexpected output", 1, 0);
        end else begin
          int ex, ey, t;
          ex = eq_x.pop_front();
          ey = eq_y.pop_front();
          t  = eq_t.pop_front();
          check($signed(out_x) == ex, $sformatf("R%0d x", t), longint'($signed(out_x)), ex);
          check($signed(out_y) == ey, $sformatf("R%0d y", t), longint'($signed(out_y)), ey);
        end
      end
    end
  end

  task automatic send(input longint x, input longint y, input int tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_x = DW'(x);
    in_y = DW'(y);
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    eq_x.push_back(exp_out(x, cmin[0], crat[0]));
    eq_y.push_back(exp_out(y, cmin[1], crat[1]));
    eq_t.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pulse_cfg(input longint mnx, input longint mny, input longint mxx,
                           input longint mxy, input longint sw, input longint sh);
    @(negedge clk);
    cfg_min_x = DW'(mnx); cfg_min_y = DW'(mny);
    cfg_max_x = DW'(mxx); cfg_max_y = DW'(mxy);
    cfg_scr_w = DW'(sw);  cfg_scr_h = DW'(sh);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    #2;
    check(!in_ready, "R8 in_ready after load", longint'(in_ready), 0);
    cmin[0] = mnx; cmin[1] = mny;
    crat[0] = exp_ratio(sw, mxx - mnx);
    crat[1] = exp_ratio(sh, mxy - mny);
    cerr[0] = (mxx - mnx) <= 0;
    cerr[1] = (mxy - mny) <= 0;
  endtask

  task automatic wait_ready(input int limit);
    int n = 0;
    while (!ratio_ready && n < 400) begin
      if (in_ready) check(1'b0, "R2 in_ready before factors", 1, 0);
      @(negedge clk);
      #2;
      n++;
    end
    check(ratio_ready && n <= limit, "R2 factor latency", n, limit);
    check(cfg_err == {cerr[1], cerr[0]}, "R5 error bits", cfg_err, {cerr[1], cerr[0]});
  endtask

  task automatic drain();
    int n = 0;
    while ((eq_x.size() != 0 || out_valid) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(eq_x.size() == 0, "R6 all outputs delivered", eq_x.size(), 0);
  endtask

  task automatic sweep(input longint x0, input longint dx, input longint y0, input longint dy, input int tag);
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        send(x0 + i * dx, y0 + j * dy, tag);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; cfg_load = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0;
    cfg_min_x = '0; cfg_min_y = '0; cfg_max_x = '0; cfg_max_y = '0;
    cfg_scr_w = '0; cfg_scr_h = '0;
    for (int k = 0; k < 2; k++) begin cmin[k] = 0; crat[k] = 0; cerr[k] = 0; end
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    check(!ratio_ready && !in_ready && !out_valid, "R1 reset outputs",
          {ratio_ready, in_ready, out_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(!ratio_ready && !in_ready && !out_valid, "R1 idle after reset",
          {ratio_ready, in_ready, out_valid}, 0);
    in_valid = 1'b0;

    // R3: offset box, one-in-three stall
    pulse_cfg(fx(-10.0), fx(-5.0), fx(30.0), fx(15.0), fx(640.0), fx(480.0));
    wait_ready(DW + FRAC + 4);
    rd_mode = 1;
    sweep(fx(-10.0) + 17, fx(5.0) + 9, fx(-5.0) + 3, fx(2.5) + 21, 3);
    drain();

    // R8: reload with a full pipeline; old vertices keep the old factors
    rd_mode = 2;
    send(fx(1.5), fx(-2.25), 8);
    send(fx(7.75), fx(3.0), 8);
    pulse_cfg(0, 0, fx(3.0), fx(7.0), fx(100.0), fx(100.0));
    repeat (70) @(negedge clk);
    #2;
    check(!ratio_ready && !in_ready, "R8 factors wait for drain", ratio_ready, 0);
    rd_mode = 0;
    wait_ready(DW + FRAC + 8);
    drain();

    // R4: zero lower corner, multiply-only state, inexact factors
    rd_mode = 1;
    sweep(0, fx(0.375) + 5, 0, fx(0.875) - 3, 4);
    sweep(fx(-1.0), fx(0.5), fx(-2.0), fx(1.0), 4);
    drain();

    // R5: empty x span
    pulse_cfg(fx(2.0), fx(-1.0), fx(2.0), fx(9.0), fx(320.0), fx(200.0));
    wait_ready(DW + FRAC + 4);
    sweep(fx(-3.0), fx(1.0), fx(-1.0), fx(1.25), 5);
    drain();

    // R9: one-LSB x span clips the factor and the outputs; reversed y span
    pulse_cfg(0, fx(5.0), 1, fx(1.0), fx(4096.0), fx(64.0));
    wait_ready(DW + FRAC + 4);
    rd_mode = 0;
    send(fx(100.0), fx(2.0), 9);
    send(fx(-100.0), fx(3.0), 9);
    send(0, 0, 9);
    send(1, fx(-4.0), 9);
    sweep(fx(-4.0), fx(1.0), fx(-4.0), fx(1.0), 9);
    drain();

    // R5: error bits clear on a valid box; R2 all-error box readies fast
    pulse_cfg(fx(1.0), fx(1.0), fx(0.5), fx(0.5), fx(10.0), fx(10.0));
    wait_ready(4);
    send(fx(3.0), fx(4.0), 5);
    drain();
    pulse_cfg(fx(-20.0), fx(-20.0), fx(200.0), fx(100.0), fx(1920.0), fx(1080.0));
    wait_ready(DW + FRAC + 4);
    rd_mode = 1;
    sweep(fx(-20.0), fx(27.5) + 1, fx(-20.0), fx(15.0) - 1, 3);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule